// File: doc/BRIEF.md
# Circular Data Link Transmit Buffer

This block feeds a data link channel on a framed serial line. A processor loads payload bytes one per write strobe and closes a message with an end-of-message strobe. The block then hands the stored bits, least significant bit first, to the line at each "bit opportunity". An opportunity is either an enabled bit position of the selected time slot or, when the overhead channel is selected, each overhead framing bit. Frame, slot and multiframe timing arrive as strobes from the framer. The block makes no timing of its own.

Two modes are available. In repeat mode, written bytes go into a shadow bank and are not sent until end-of-message. The committed message becomes active at the next multiframe start, and it is replayed with wrap-around until a newer commit takes its place at a later multiframe start. In FIFO mode, bytes are sent once in write order, with no wait for a multiframe boundary. Each byte carries either 6 or 8 payload bits. Any enabled bit that has no data to carry is sent as a one.

Top module: `dl_tx_circ_buf`

## Requirements
- R1: After reset, dl_vld_o is 0, dl_bit_o is 1 and overflow_o is 0.
- R2: With ovh_sel_i=0, a cycle with slot_bit_i=1 and bit_mask_i[slot_pos_i]=1 is an opportunity. Mask bit 0 belongs to slot_pos_i=0, the first bit of the slot, and mask bit 7 belongs to slot_pos_i=7. dl_vld_o is 1 in the cycle after an opportunity and 0 after any other cycle.
- R3: With ovh_sel_i=1, every cycle with ovh_bit_i=1 is an opportunity, and bit_mask_i and slot_bit_i have no effect.
- R4: Payload bits leave LSB first. pack8_i=1 sends bits 0..7 of each byte. pack8_i=0 sends bits 0..5, and bits 7:6 are never sent.
- R5: An opportunity that has no data to carry sends dl_bit_o=1. dl_bit_o is 1 whenever dl_vld_o is 0.
- R6: In repeat mode (repeat_en_i=1), written bytes are not sent before an end-of-message strobe.
- R7: After end-of-message in repeat mode, the first bit of byte 0 is sent on the first opportunity that falls in or after the next cycle with mf_start_i=1. An opportunity in the same cycle as mf_start_i counts.
- R8: In repeat mode, the bit after the last bit of the last byte is bit 0 of byte 0. The message repeats without end.
- R9: A message committed while another is repeating replaces it only at the next mf_start_i. Until then, the old message continues from its current position.
- R10: In repeat mode, a write made while a commit is pending is dropped, and an end-of-message with no bytes written since the last commit is ignored.
- R11: In FIFO mode (repeat_en_i=0), bytes are sent once in write order without waiting for mf_start_i, and eom_i has no effect.
- R12: In either mode, a write when 64 bytes are already held is dropped and sets overflow_o. overflow_o stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| repeat_en_i | input | 1 | 1 selects repeat mode, 0 selects FIFO mode |
| pack8_i | input | 1 | 1 sends 8 bits per byte, 0 sends 6 bits per byte |
| wr_en_i | input | 1 | Byte write strobe |
| wr_data_i | input | 8 | Byte to store |
| eom_i | input | 1 | End-of-message strobe (repeat mode) |
| bit_mask_i | input | 8 | Per-position enable within the time slot |
| ovh_sel_i | input | 1 | 1 selects the overhead framing bit channel |
| slot_bit_i | input | 1 | Strobe for one bit time of the selected slot |
| slot_pos_i | input | 3 | Bit position within the slot, 0 is the first |
| ovh_bit_i | input | 1 | Strobe for an overhead framing bit time |
| mf_start_i | input | 1 | Start of an output multiframe |
| dl_vld_o | output | 1 | dl_bit_o carries a data link bit this cycle |
| dl_bit_o | output | 1 | Data link bit |
| overflow_o | output | 1 | Sticky flag for a dropped write to a full buffer |

## Verification
The assertions assume that repeat_en_i and pack8_i change only while reset is held. They also assume that the strobes are low during reset and that all inputs are settled at each rising edge. The bench changes the mode and the pack width only inside its reset task. It drives every input 1 ns after a rising edge and clears every strobe before it asserts or releases reset. Under these conditions the one-cycle relations between an opportunity and dl_vld_o, and the sticky overflow, hold from the first edge after reset.

// File: rtl/dl_tx_pkg.sv
package dl_tx_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic {
    PACK6 = 1'b0,
    PACK8 = 1'b1
  } pack_e;

  function automatic logic [2:0] last_bit(input pack_e p);
    return (p == PACK8) ? 3'd7 : 3'd5;
  endfunction
endpackage

// File: rtl/dl_tx_slot_gate.sv
module dl_tx_slot_gate #(
  parameter int SLOT_BITS = 8
) (
  input  logic                         ovh_sel_i,
  input  logic                         ovh_bit_i,
  input  logic                         slot_bit_i,
  input  logic [$clog2(SLOT_BITS)-1:0] slot_pos_i,
  input  logic [SLOT_BITS-1:0]         bit_mask_i,
  output logic                         take_o
);
  localparam int PW = $clog2(SLOT_BITS);

  logic [SLOT_BITS-1:0] hit;

  for (genvar g = 0; g < SLOT_BITS; g++) begin : g_pos
    assign hit[g] = slot_bit_i && bit_mask_i[g] && (slot_pos_i == PW'(g));
  end

  // overhead channel bypasses the mask
  assign take_o = ovh_sel_i ? ovh_bit_i : |hit;
endmodule

// File: rtl/dl_tx_store.sv
module dl_tx_store #(
  parameter int DEPTH = 64
) (
  input  logic                              clk_i,
  input  logic                              we_i,
  input  logic [$clog2(DEPTH):0]            waddr_i,
  input  logic [dl_tx_pkg::BYTE_W-1:0]      wdata_i,
  input  logic [$clog2(DEPTH):0]            raddr_i,
  output logic [dl_tx_pkg::BYTE_W-1:0]      rdata_o
);
  localparam int ENTRIES = 2 * DEPTH;

  logic [dl_tx_pkg::BYTE_W-1:0] mem_q [ENTRIES];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dl_tx_seq.sv
module dl_tx_seq
  import dl_tx_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   rep_i,
  input  logic                   pack8_i,
  input  logic                   wr_i,
  input  logic                   eom_i,
  input  logic                   mf_i,
  input  logic                   take_i,
  input  logic [BYTE_W-1:0]      rdata_i,
  output logic                   we_o,
  output logic [$clog2(DEPTH):0] waddr_o,
  output logic [$clog2(DEPTH):0] raddr_o,
  output logic                   bit_o,
  output logic                   ovf_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  // repeat-mode state
  logic          play_bank_q, act_q, pend_q;
  logic [CW-1:0] play_len_q, pend_len_q, wcnt_q;
  logic [AW-1:0] rd_q;
  // fifo-mode state
  logic [AW-1:0] f_wr_q, f_rd_q;
  logic [CW-1:0] f_cnt_q;
  // shared
  logic [2:0]    bit_q;
  logic          ovf_q;

  logic          swap, have, step, byte_end, rd_wrap, pop;
  logic          c_acc, f_acc, drop_full, commit;
  logic          e_bank;
  logic [AW-1:0] e_rd;
  logic [2:0]    e_bit, nxt_bit;
  logic [CW-1:0] e_len;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  // a pending commit takes over in the boundary cycle itself
  assign swap   = rep_i && mf_i && pend_q;
  assign e_bank = swap ? ~play_bank_q : play_bank_q;
  assign e_rd   = swap ? '0 : rd_q;
  assign e_bit  = swap ? '0 : bit_q;
  assign e_len  = swap ? pend_len_q : play_len_q;

  assign have     = rep_i ? (swap || act_q) : (f_cnt_q != '0);
  assign step     = take_i && have;
  assign byte_end = (e_bit == last_bit(pack_e'(pack8_i)));
  assign nxt_bit  = byte_end ? 3'd0 : e_bit + 3'd1;
  assign rd_wrap  = ({1'b0, e_rd} == e_len - CW'(1));
  assign pop      = !rep_i && step && byte_end;

  assign c_acc     = rep_i && wr_i && !pend_q && (wcnt_q != FULL);
  assign f_acc     = !rep_i && wr_i && (f_cnt_q != FULL);
  assign drop_full = wr_i && (rep_i ? (!pend_q && wcnt_q == FULL) : (f_cnt_q == FULL));
  assign commit    = rep_i && eom_i && !pend_q && ((wcnt_q != '0) || c_acc);

  assign we_o    = c_acc || f_acc;
  assign waddr_o = rep_i ? {~play_bank_q, wcnt_q[AW-1:0]} : {1'b0, f_wr_q};
  assign raddr_o = rep_i ? {e_bank, e_rd} : {1'b0, f_rd_q};
  assign bit_o   = have ? rdata_i[e_bit] : 1'b1;
  assign ovf_o   = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      play_bank_q <= 1'b0;
      act_q       <= 1'b0;
      pend_q      <= 1'b0;
      play_len_q  <= '0;
      pend_len_q  <= '0;
      wcnt_q      <= '0;
      rd_q        <= '0;
      f_wr_q      <= '0;
      f_rd_q      <= '0;
      f_cnt_q     <= '0;
      bit_q       <= '0;
      ovf_q       <= 1'b0;
    end else begin
      if (drop_full) ovf_q <= 1'b1;
      bit_q <= step ? nxt_bit : e_bit;
      if (rep_i) begin
        if (commit) begin
          pend_q     <= 1'b1;
          pend_len_q <= wcnt_q + CW'(c_acc);
          wcnt_q     <= '0;
        end else if (c_acc) begin
          wcnt_q <= wcnt_q + CW'(1);
        end
        if (swap) begin
          play_bank_q <= ~play_bank_q;
          play_len_q  <= pend_len_q;
          act_q       <= 1'b1;
          pend_q      <= 1'b0;
        end
        if (step && byte_end) rd_q <= rd_wrap ? '0 : e_rd + AW'(1);
        else                  rd_q <= e_rd;
      end else begin
        if (f_acc) f_wr_q <= ptr_inc(f_wr_q);
        if (pop)   f_rd_q <= ptr_inc(f_rd_q);
        f_cnt_q <= f_cnt_q + CW'(f_acc) - CW'(pop);
      end
    end
  end
endmodule

// File: rtl/dl_tx_circ_buf.sv
module dl_tx_circ_buf
  import dl_tx_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int SLOT_BITS = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         repeat_en_i,
  input  logic                         pack8_i,
  input  logic                         wr_en_i,
  input  logic [BYTE_W-1:0]            wr_data_i,
  input  logic                         eom_i,
  input  logic [SLOT_BITS-1:0]         bit_mask_i,
  input  logic                         ovh_sel_i,
  input  logic                         slot_bit_i,
  input  logic [$clog2(SLOT_BITS)-1:0] slot_pos_i,
  input  logic                         ovh_bit_i,
  input  logic                         mf_start_i,
  output logic                         dl_vld_o,
  output logic                         dl_bit_o,
  output logic                         overflow_o
);
  localparam int AW = $clog2(DEPTH);

  logic              take, line_bit, we;
  logic [AW:0]       waddr, raddr;
  logic [BYTE_W-1:0] rdata;
  logic              vld_q, bit_q;

  dl_tx_slot_gate #(.SLOT_BITS(SLOT_BITS)) u_gate (
    .ovh_sel_i  (ovh_sel_i),
    .ovh_bit_i  (ovh_bit_i),
    .slot_bit_i (slot_bit_i),
    .slot_pos_i (slot_pos_i),
    .bit_mask_i (bit_mask_i),
    .take_o     (take)
  );

  dl_tx_store #(.DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wr_data_i),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  dl_tx_seq #(.DEPTH(DEPTH)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rep_i   (repeat_en_i),
    .pack8_i (pack8_i),
    .wr_i    (wr_en_i),
    .eom_i   (eom_i),
    .mf_i    (mf_start_i),
    .take_i  (take),
    .rdata_i (rdata),
    .we_o    (we),
    .waddr_o (waddr),
    .raddr_o (raddr),
    .bit_o   (line_bit),
    .ovf_o   (overflow_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      bit_q <= 1'b1;
    end else begin
      vld_q <= take;
      bit_q <= take ? line_bit : 1'b1;
    end
  end

  assign dl_vld_o = vld_q;
  assign dl_bit_o = bit_q;
endmodule

// File: rtl/dl_tx_circ_buf_chk.sv
module dl_tx_circ_buf_chk #(
  parameter int SLOT_BITS = 8
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         ovh_sel_i,
  input logic                         ovh_bit_i,
  input logic                         slot_bit_i,
  input logic [$clog2(SLOT_BITS)-1:0] slot_pos_i,
  input logic [SLOT_BITS-1:0]         bit_mask_i,
  input logic                         wr_en_i,
  input logic                         dl_vld_o,
  input logic                         dl_bit_o,
  input logic                         overflow_o
);
  // R2
  slot_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovh_sel_i && slot_bit_i && bit_mask_i[slot_pos_i]) |=> dl_vld_o);

  // R2
  masked_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovh_sel_i && !(slot_bit_i && bit_mask_i[slot_pos_i])) |=> !dl_vld_o);

  // R3
  ovh_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovh_sel_i |=> (dl_vld_o == $past(ovh_bit_i)));

  // R5
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dl_vld_o |-> dl_bit_o);

  // R12
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  // R12
  ovf_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overflow_o) |-> $past(wr_en_i));
endmodule

bind dl_tx_circ_buf dl_tx_circ_buf_chk #(.SLOT_BITS(SLOT_BITS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ovh_sel_i  (ovh_sel_i),
  .ovh_bit_i  (ovh_bit_i),
  .slot_bit_i (slot_bit_i),
  .slot_pos_i (slot_pos_i),
  .bit_mask_i (bit_mask_i),
  .wr_en_i    (wr_en_i),
  .dl_vld_o   (dl_vld_o),
  .dl_bit_o   (dl_bit_o),
  .overflow_o (overflow_o)
);

// File: tb/tb_dl_tx_circ_buf.sv
module tb_dl_tx_circ_buf;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       repeat_en_i = 1'b1, pack8_i = 1'b1;
  logic       wr_en_i = 1'b0, eom_i = 1'b0;
  logic [7:0] wr_data_i = '0, bit_mask_i = '0;
  logic       ovh_sel_i = 1'b0, slot_bit_i = 1'b0, ovh_bit_i = 1'b0, mf_start_i = 1'b0;
  logic [2:0] slot_pos_i = '0;
  logic       dl_vld_o, dl_bit_o, overflow_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] mbuf [64];
  int         mlen;

  always #2.5 clk_i = ~clk_i;

  dl_tx_circ_buf dut (.*);

  // {ovh_sel, ovh_bit, slot_bit, pos[2:0], mask[7:0], exp_vld}
  localparam logic [14:0] VEC [10] = '{
    {1'b0, 1'b0, 1'b1, 3'd0, 8'h01, 1'b1},
    {1'b0, 1'b0, 1'b1, 3'd0, 8'hFE, 1'b0},
    {1'b0, 1'b0, 1'b1, 3'd7, 8'h80, 1'b1},
    {1'b0, 1'b0, 1'b1, 3'd7, 8'h7F, 1'b0},
    {1'b0, 1'b0, 1'b0, 3'd3, 8'hFF, 1'b0},
    {1'b0, 1'b0, 1'b1, 3'd3, 8'h08, 1'b1},
    {1'b0, 1'b0, 1'b1, 3'd4, 8'h08, 1'b0},
    {1'b1, 1'b1, 1'b0, 3'd0, 8'h00, 1'b1},
    {1'b1, 1'b0, 1'b1, 3'd0, 8'hFF, 1'b0},
    {1'b0, 1'b1, 1'b0, 3'd0, 8'hFF, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic do_reset(input logic rep, input logic p8);
    wr_en_i = 0; eom_i = 0; slot_bit_i = 0; ovh_bit_i = 0; ovh_sel_i = 0; mf_start_i = 0;
    rst_ni = 0;
    repeat_en_i = rep; pack8_i = p8;
    tick(); tick();
    rst_ni = 1;
    tick();
  endtask

  task automatic wr_byte(input logic [7:0] d);
    wr_en_i = 1; wr_data_i = d;
    tick();
    wr_en_i = 0;
  endtask

  task automatic pulse_eom();
    eom_i = 1;
    tick();
    eom_i = 0;
  endtask

  task automatic take_bit(input logic mf, output logic b);
    ovh_sel_i = 0; slot_bit_i = 1; slot_pos_i = 3'd0; bit_mask_i = 8'h01; mf_start_i = mf;
    tick();
    b = dl_bit_o;
    slot_bit_i = 0; mf_start_i = 0;
  endtask

  function automatic logic exp_bit(input int k);
    int bpb = pack8_i ? 8 : 6;
    return mbuf[(k / bpb) % mlen][k % bpb];
  endfunction

  task automatic stream(input int k0, input int n, input string tag);
    logic b;
    for (int i = 0; i < n; i++) begin
      take_bit(1'b0, b);
      chk(tag, b, exp_bit(k0 + i));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic b;
    do_reset(1'b1, 1'b1);
    // R1
    chk("R1 vld", dl_vld_o, 0);
    chk("R1 bit", dl_bit_o, 1);
    chk("R1 ovf", overflow_o, 0);

    // R2 R3 R5: gating table, nothing committed
    for (int i = 0; i < 10; i++) begin
      {ovh_sel_i, ovh_bit_i, slot_bit_i, slot_pos_i, bit_mask_i} = VEC[i][14:1];
      tick();
      chk("R2 R3 gate vld", dl_vld_o, VEC[i][0]);
      chk("R5 idle bit", dl_bit_o, 1);
      ovh_sel_i = 0; ovh_bit_i = 0; slot_bit_i = 0;
    end

    // R6 R7 R8: repeat mode, two bytes
    mbuf[0] = 8'h5A; mbuf[1] = 8'hC3; mlen = 2;
    wr_byte(8'h5A); wr_byte(8'hC3);
    take_bit(1'b0, b); chk("R6 held before eom", b, 1);
    pulse_eom();
    take_bit(1'b0, b); chk("R7 wait for mf", b, 1);
    take_bit(1'b1, b); chk("R7 first bit at mf", b, exp_bit(0));
    stream(1, 15, "R4 lsb-first stream");
    stream(16, 16, "R8 wrap");

    // R9 R10: replace at boundary, pending write dropped, empty eom ignored
    wr_byte(8'hF0);
    pulse_eom();
    wr_byte(8'hFF);
    stream(32, 3, "R9 old continues");
    mbuf[0] = 8'hF0; mlen = 1;
    take_bit(1'b1, b); chk("R9 swap at mf", b, exp_bit(0));
    stream(1, 15, "R10 pending write dropped");
    stream(16, 4, "R10 stream");
    pulse_eom();
    take_bit(1'b1, b); chk("R10 empty eom ignored", b, exp_bit(20));

    // R4: six-bit packing
    do_reset(1'b1, 1'b0);
    mbuf[0] = 8'hD5; mlen = 1;
    wr_byte(8'hD5);
    pulse_eom();
    take_bit(1'b1, b); chk("R4 pack6 first", b, exp_bit(0));
    stream(1, 11, "R4 pack6 stream");

    // R11: fifo mode
    do_reset(1'b0, 1'b1);
    mbuf[0] = 8'h5A; mbuf[1] = 8'h0F; mlen = 2;
    wr_byte(8'h5A); wr_byte(8'h0F);
    stream(0, 8, "R11 fifo no mf wait");
    pulse_eom();
    stream(8, 8, "R11 fifo eom ignored");
    for (int i = 0; i < 8; i++) begin
      take_bit(1'b0, b); chk("R11 R5 drained ones", b, 1);
    end

    // R12: fifo overflow
    do_reset(1'b0, 1'b1);
    for (int i = 0; i < 64; i++) begin
      mbuf[i] = 8'(i * 5 + 1);
      wr_byte(8'(i * 5 + 1));
    end
    mlen = 64;
    chk("R12 no ovf at 64", overflow_o, 0);
    wr_byte(8'hFF);
    chk("R12 ovf set", overflow_o, 1);
    stream(0, 512, "R12 fifo content");
    take_bit(1'b0, b); chk("R12 extra write dropped", b, 1);
    chk("R12 ovf sticky", overflow_o, 1);

    // R12: repeat-mode overflow
    do_reset(1'b1, 1'b1);
    for (int i = 0; i < 65; i++) wr_byte(i < 64 ? 8'(i * 5 + 1) : 8'hFF);
    chk("R12 ovf repeat", overflow_o, 1);
    pulse_eom();
    take_bit(1'b1, b); chk("R12 repeat first", b, exp_bit(0));
    stream(1, 519, "R12 R8 repeat wrap at 64");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule